// File: doc/BRIEF.md
# Low-Transition Bus Codec

This block is a matched transmitter and receiver for a wide parallel data bus. Its aim is to cut the number of wires that change level from one transfer to the next. The transmitter takes a data word and a requested coding mode, and drives the bus data lines with a small set of side-band lines. The receiver turns the bus state back into the original word. A pair of running counters compares the toggles seen on the coded lines with the toggles a plain bus would have made for the same words.

The block has two ways to save toggles.

- **Signed coding.** A negative two's-complement word goes out with its sign bit left as it is and every other bit inverted. The sign bit itself tells the receiver how to undo the inversion, so no extra polarity wire is needed.
- **Freeze coding.** For address-like streams the transmitter can leave the data lines exactly as they were and raise a step line. It does this when the new word is the expected successor of the previous one. There are two freeze modes:
  - *Sequential:* the successor is the previous word plus one, wrapping at the word width.
  - *Pattern:* the stream is a fixed counting loop from zero up to a parameter limit, followed by zero again.

The receiver keeps its own copy of the last word it rebuilt. When it sees the step line, it computes the successor from that copy.

Both sides start from a previous word of zero after reset. The first transfer after reset always goes out uncoded. The transmitter registers the bus lines at the edge where it samples a word. The receiver registers the rebuilt word one edge later.

Top module: `lowtog_link`

## Requirements
- R1: While reset is held and right after it, the block drives zero on these outputs: `bus_data`, `bus_valid`, `bus_step`, `bus_mode`, `out_valid`, `out_data`, `toggles_coded` and `toggles_plain`.
- R2: `bus_mode` carries the coding actually applied. The codes are plain = 0, signed = 1, sequential = 2 and pattern = 3. The requested mode on `in_mode` uses the same codes. In plain mode, `bus_data` equals the word and `bus_step` is 0.
- R3: In signed mode, `bus_data` bit W-1 equals the word's bit W-1. Bits W-2..0 are the word's bits inverted when bit W-1 is 1, and passed unchanged when it is 0. `bus_step` is 0.
- R4: In sequential mode, when the word equals the previous word plus one modulo 2^W, `bus_data` keeps its previous value and `bus_step` is 1. Otherwise `bus_data` equals the word and `bus_step` is 0.
- R5: In pattern mode the successor of x is 0 when x equals PAT_LAST, and x+1 otherwise. A word equal to the successor of the previous word freezes `bus_data` and sets `bus_step` to 1. Any other word is sent plain with `bus_step` at 0.
- R6: The first transfer after reset is sent with `bus_data` equal to the word, `bus_mode` = 0 and `bus_step` = 0, whatever mode is requested.
- R7: A word sampled with `in_valid` at edge k appears on the bus after edge k. It appears on `out_data`, with `out_valid` at 1, after edge k+1. `out_data` equals the sampled word for every mode.
- R8: An edge with `in_valid` low leaves `bus_data`, `bus_step` and `bus_mode` unchanged and brings `bus_valid` low. It also brings `out_valid` low one edge later.
- R9: `toggles_coded` adds the number of `bus_data` bits that changed at each bus update. `toggles_plain` adds the number of bits that differ between each accepted word and the word accepted before it, starting from zero. Both counts appear one edge after the bus update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word present on this edge |
| in_mode | input | 2 | Requested coding: 0 plain, 1 signed, 2 sequential, 3 pattern |
| in_data | input | W | Word to transfer |
| bus_valid | output | 1 | Bus carries a new transfer |
| bus_step | output | 1 | Bus data frozen, word is the successor |
| bus_mode | output | 2 | Coding applied to this transfer |
| bus_data | output | W | Coded bus data lines |
| out_valid | output | 1 | Rebuilt word valid |
| out_data | output | W | Rebuilt word |
| toggles_coded | output | CNT_W | Accumulated toggles on coded data lines |
| toggles_plain | output | CNT_W | Accumulated toggles a plain bus would show |

## Verification
The bench builds the codec with W = 8 and PAT_LAST = 10. This makes it practical to sweep all 256 word values through the plain and signed codings, and to run a full ramp through 255 and back to 0 in sequential mode. The pattern loop and its break-out cases are short enough to cover completely. The bench checks every transfer for bus lines, step, mode, the rebuilt word and both toggle counts against an arithmetic model. A back-to-back burst that changes mode on every transfer covers the one-edge pipeline between transmitter and receiver.

// File: rtl/lowtog_pkg.sv
package lowtog_pkg;

    // Coding applied to one transfer; the same codes travel on the mode lines.
    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'd0,
        MODE_SIGNED = 2'd1,
        MODE_SEQ    = 2'd2,
        MODE_PAT    = 2'd3
    } lt_mode_e;

endpackage

// File: rtl/lowtog_successor.sv
// Expected next word of a freeze-coded stream.
module lowtog_successor #(
    parameter int W        = 32,
    parameter int PAT_LAST = 10
) (
    input  logic [W-1:0] cur,
    input  logic [1:0]   mode,
    output logic [W-1:0] nxt
);
    import lowtog_pkg::*;

    localparam logic [W-1:0] LAST_WORD = W'(PAT_LAST);
    localparam logic [W-1:0] ONE_WORD  = W'(1);

    always_comb begin
        if (lt_mode_e'(mode) == MODE_PAT && cur == LAST_WORD) begin
            nxt = '0;
        end else begin
            nxt = cur + ONE_WORD;
        end
    end
endmodule

// File: rtl/lowtog_fold.sv
// Sign-controlled polarity fold; applying it twice gives the input back.
module lowtog_fold #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LOW_W = W - 1;

    logic [LOW_W-1:0] mask;

    always_comb begin
        mask = {LOW_W{din[W-1]}};
        dout = {din[W-1], din[LOW_W-1:0] ^ mask};
    end
endmodule

// File: rtl/lowtog_enc.sv
// Transmitter: picks the coding of each word and drives the bus lines.
module lowtog_enc #(
    parameter int W        = 32,
    parameter int PAT_LAST = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   in_mode,
    input  logic [W-1:0] in_data,
    output logic         bus_valid,
    output logic         bus_step,
    output logic [1:0]   bus_mode,
    output logic [W-1:0] bus_data,
    output logic [W-1:0] last_word
);
    import lowtog_pkg::*;

    // State names the kind of the last transfer; FRESH means none since reset.
    typedef enum logic [1:0] {
        E_FRESH = 2'd0,
        E_RAW   = 2'd1,
        E_INV   = 2'd2,
        E_HOLD  = 2'd3
    } enc_state_e;

    enc_state_e state_q, state_d;
    logic [W-1:0] lines_q, lines_d;
    logic [W-1:0] prev_q, prev_d;
    lt_mode_e     mode_q, mode_d;
    logic         valid_q;

    logic [W-1:0] succ_word;
    logic [W-1:0] folded_word;

    lowtog_successor #(.W(W), .PAT_LAST(PAT_LAST)) i_succ (
        .cur  (prev_q),
        .mode (in_mode),
        .nxt  (succ_word)
    );

    lowtog_fold #(.W(W)) i_fold (
        .din  (in_data),
        .dout (folded_word)
    );

    // Next-state and next-lines decision.
    always_comb begin
        state_d = state_q;
        lines_d = lines_q;
        prev_d  = prev_q;
        mode_d  = mode_q;
        if (in_valid) begin
            prev_d = in_data;
            unique case (state_q)
                E_FRESH: begin
                    state_d = E_RAW;
                    lines_d = in_data;
                    mode_d  = MODE_PLAIN;
                end
                E_RAW, E_INV, E_HOLD: begin
                    mode_d = lt_mode_e'(in_mode);
                    unique case (lt_mode_e'(in_mode))
                        MODE_PLAIN: begin
                            state_d = E_RAW;
                            lines_d = in_data;
                        end
                        MODE_SIGNED: begin
                            state_d = in_data[W-1] ? E_INV : E_RAW;
                            lines_d = folded_word;
                        end
                        MODE_SEQ, MODE_PAT: begin
                            if (in_data == succ_word) begin
                                state_d = E_HOLD;
                            end else begin
                                state_d = E_RAW;
                                lines_d = in_data;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= E_FRESH;
            lines_q <= '0;
            prev_q  <= '0;
            mode_q  <= MODE_PLAIN;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            lines_q <= lines_d;
            prev_q  <= prev_d;
            mode_q  <= mode_d;
            valid_q <= in_valid;
        end
    end

    // Outputs from the registered state.
    always_comb begin
        bus_valid = valid_q;
        bus_data  = lines_q;
        bus_mode  = mode_q;
        last_word = prev_q;
        unique case (state_q)
            E_HOLD:                 bus_step = 1'b1;
            E_FRESH, E_RAW, E_INV:  bus_step = 1'b0;
        endcase
    end
endmodule

// File: rtl/lowtog_dec.sv
// Receiver: rebuilds each word from the bus and its own last copy.
module lowtog_dec #(
    parameter int W        = 32,
    parameter int PAT_LAST = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_valid,
    input  logic         bus_step,
    input  logic [1:0]   bus_mode,
    input  logic [W-1:0] bus_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    import lowtog_pkg::*;

    typedef enum logic {
        D_EMPTY = 1'b0,
        D_LIVE  = 1'b1
    } dec_state_e;

    dec_state_e   state_q, state_d;
    logic [W-1:0] word_q, word_d;
    logic         valid_q;

    logic [W-1:0] succ_word;
    logic [W-1:0] unfolded_word;

    lowtog_successor #(.W(W), .PAT_LAST(PAT_LAST)) i_succ (
        .cur  (word_q),
        .mode (bus_mode),
        .nxt  (succ_word)
    );

    lowtog_fold #(.W(W)) i_unfold (
        .din  (bus_data),
        .dout (unfolded_word)
    );

    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        if (bus_valid) begin
            unique case (state_q)
                D_EMPTY: begin
                    state_d = D_LIVE;
                    word_d  = bus_data;
                end
                D_LIVE: begin
                    if (bus_step) begin
                        word_d = succ_word;
                    end else if (lt_mode_e'(bus_mode) == MODE_SIGNED) begin
                        word_d = unfolded_word;
                    end else begin
                        word_d = bus_data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= D_EMPTY;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            valid_q <= bus_valid;
        end
    end

    always_comb begin
        out_valid = valid_q;
        out_data  = word_q;
    end
endmodule

// File: rtl/lowtog_meter.sv
// Toggle meter: coded data lines against the plain word stream.
module lowtog_meter #(
    parameter int W     = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     coded_lines,
    input  logic [W-1:0]     plain_word,
    output logic [CNT_W-1:0] toggles_coded,
    output logic [CNT_W-1:0] toggles_plain
);
    logic [W-1:0]     coded_last_q;
    logic [W-1:0]     plain_last_q;
    logic [CNT_W-1:0] coded_cnt_q;
    logic [CNT_W-1:0] plain_cnt_q;
    logic [CNT_W-1:0] coded_flips;
    logic [CNT_W-1:0] plain_flips;

    function automatic logic [CNT_W-1:0] flips(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [CNT_W-1:0] sum;
        logic [W-1:0]     diff;
        sum  = '0;
        diff = a ^ b;
        for (int i = 0; i < W; i++) begin
            sum = sum + {{(CNT_W-1){1'b0}}, diff[i]};
        end
        return sum;
    endfunction

    always_comb begin
        coded_flips = flips(coded_lines, coded_last_q);
        plain_flips = flips(plain_word, plain_last_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coded_last_q <= '0;
            plain_last_q <= '0;
            coded_cnt_q  <= '0;
            plain_cnt_q  <= '0;
        end else begin
            coded_last_q <= coded_lines;
            plain_last_q <= plain_word;
            coded_cnt_q  <= coded_cnt_q + coded_flips;
            plain_cnt_q  <= plain_cnt_q + plain_flips;
        end
    end

    always_comb begin
        toggles_coded = coded_cnt_q;
        toggles_plain = plain_cnt_q;
    end
endmodule

// File: rtl/lowtog_link.sv
// Top: transmitter, receiver and toggle meter on one bus.
module lowtog_link #(
    parameter int W        = 32,
    parameter int PAT_LAST = 10,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic [W-1:0]     in_data,
    output logic             bus_valid,
    output logic             bus_step,
    output logic [1:0]       bus_mode,
    output logic [W-1:0]     bus_data,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    output logic [CNT_W-1:0] toggles_coded,
    output logic [CNT_W-1:0] toggles_plain
);
    logic [W-1:0] last_word;

    lowtog_enc #(.W(W), .PAT_LAST(PAT_LAST)) i_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .bus_valid (bus_valid),
        .bus_step  (bus_step),
        .bus_mode  (bus_mode),
        .bus_data  (bus_data),
        .last_word (last_word)
    );

    lowtog_dec #(.W(W), .PAT_LAST(PAT_LAST)) i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_step  (bus_step),
        .bus_mode  (bus_mode),
        .bus_data  (bus_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    lowtog_meter #(.W(W), .CNT_W(CNT_W)) i_meter (
        .clk           (clk),
        .rst_n         (rst_n),
        .coded_lines   (bus_data),
        .plain_word    (last_word),
        .toggles_coded (toggles_coded),
        .toggles_plain (toggles_plain)
    );
endmodule

// File: rtl/lowtog_link_chk.sv
module lowtog_link_chk #(
    parameter int W     = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     in_data,
    input logic             bus_valid,
    input logic             bus_step,
    input logic [1:0]       bus_mode,
    input logic [W-1:0]     bus_data,
    input logic             out_valid,
    input logic [CNT_W-1:0] toggles_coded
);
    localparam logic [CNT_W-1:0] MAX_FLIPS = CNT_W'(W);

    AST_FREEZE_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_step) |-> (bus_data == $past(bus_data))); // R4

    AST_STEP_NEEDS_FREEZE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_step) |-> bus_mode[1]); // R5

    AST_SIGN_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_mode == 2'd1) |-> (bus_data[W-1] == $past(in_data[W-1]))); // R3

    AST_BUS_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> bus_valid); // R7

    AST_OUT_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> out_valid); // R7

    AST_IDLE_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(bus_data) && $stable(bus_step) && $stable(bus_mode) && !bus_valid)); // R8

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !out_valid); // R8

    AST_TOGGLE_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((toggles_coded - $past(toggles_coded)) <= MAX_FLIPS)); // R9
endmodule

bind lowtog_link lowtog_link_chk #(.W(W), .CNT_W(CNT_W)) i_lowtog_link_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .bus_valid     (bus_valid),
    .bus_step      (bus_step),
    .bus_mode      (bus_mode),
    .bus_data      (bus_data),
    .out_valid     (out_valid),
    .toggles_coded (toggles_coded)
);

// File: tb/test_lowtog_link.sv
`timescale 1ns/1ps
module test_lowtog_link;
    localparam int W        = 8;
    localparam int PAT_LAST = 10;
    localparam int CNT_W    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       in_mode = 2'd0;
    logic [W-1:0]     in_data = '0;
    logic             bus_valid, bus_step;
    logic [1:0]       bus_mode;
    logic [W-1:0]     bus_data;
    logic             out_valid;
    logic [W-1:0]     out_data;
    logic [CNT_W-1:0] toggles_coded, toggles_plain;

    int nchk = 0;
    int nfail = 0;

    // Arithmetic model state
    bit           m_fresh;
    logic [W-1:0] m_prev, m_lines;
    int           m_coded, m_plain;
    logic [W-1:0] e_lines;
    logic         e_step;
    logic [1:0]   e_mode;

    always #4 clk = ~clk;

    lowtog_link #(.W(W), .PAT_LAST(PAT_LAST), .CNT_W(CNT_W)) i_lowtog_link (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_data(in_data),
        .bus_valid(bus_valid), .bus_step(bus_step), .bus_mode(bus_mode), .bus_data(bus_data),
        .out_valid(out_valid), .out_data(out_data),
        .toggles_coded(toggles_coded), .toggles_plain(toggles_plain)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] succ_of(input logic [W-1:0] x, input logic [1:0] md);
        if (md == 2'd3 && x == W'(PAT_LAST)) return '0;
        return x + W'(1);
    endfunction

    task automatic model(input logic [1:0] md, input logic [W-1:0] d);
        e_step = 1'b0;
        e_mode = md;
        e_lines = d;
        if (m_fresh) begin
            e_mode = 2'd0;
        end else if (md == 2'd1) begin
            e_lines = d[W-1] ? {1'b1, ~d[W-2:0]} : d;
        end else if (md[1] && d == succ_of(m_prev, md)) begin
            e_lines = m_lines;
            e_step = 1'b1;
        end
        m_coded += $countones(e_lines ^ m_lines);
        m_plain += $countones(d ^ m_prev);
        m_prev = d;
        m_lines = e_lines;
        m_fresh = 1'b0;
    endtask

    // One transfer followed by an idle edge; checks bus, output and counters.
    task automatic send(input logic [1:0] md, input logic [W-1:0] d, input string tag);
        model(md, d);
        @(negedge clk);
        in_valid = 1'b1; in_mode = md; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_mode = ~md; in_data = ~d;
        chk(bus_valid === 1'b1, {tag, " R7 bus_valid"}, int'(bus_valid), 1);
        chk(bus_data === e_lines, {tag, " bus_data"}, int'(bus_data), int'(e_lines));
        chk(bus_step === e_step, {tag, " bus_step"}, int'(bus_step), int'(e_step));
        chk(bus_mode === e_mode, {tag, " R2 bus_mode"}, int'(bus_mode), int'(e_mode));
        @(posedge clk);
        #1;
        chk(out_valid === 1'b1, {tag, " R7 out_valid"}, int'(out_valid), 1);
        chk(out_data === d, {tag, " R7 out_data"}, int'(out_data), int'(d));
        chk(bus_valid === 1'b0 && bus_data === e_lines && bus_step === e_step && bus_mode === e_mode,
            {tag, " R8 idle keeps bus"}, int'(bus_data), int'(e_lines));
        chk(toggles_coded === CNT_W'(m_coded), {tag, " R9 toggles_coded"}, int'(toggles_coded), m_coded);
        chk(toggles_plain === CNT_W'(m_plain), {tag, " R9 toggles_plain"}, int'(toggles_plain), m_plain);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        m_fresh = 1'b1; m_prev = '0; m_lines = '0; m_coded = 0; m_plain = 0;
        @(negedge clk);
        chk(bus_data === '0 && bus_valid === 1'b0 && bus_step === 1'b0 && bus_mode === 2'd0,
            "R1 bus during reset", int'(bus_data), 0);
        chk(out_valid === 1'b0 && out_data === '0, "R1 out during reset", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(toggles_coded === '0 && toggles_plain === '0, "R1 counters after reset", int'(toggles_coded), 0);
        chk(bus_valid === 1'b0 && out_valid === 1'b0, "R1 valids after reset", int'(out_valid), 0);
    endtask

    logic [W-1:0] burst_q [0:63];

    initial begin
        do_reset();

        // First transfer: successor of zero, but must go out plain.
        send(2'd2, 8'd1, "R6 first seq");
        do_reset();
        send(2'd1, 8'hC3, "R6 first signed");

        for (int v = 0; v < 256; v++) send(2'd0, W'(v), "R2 plain sweep");
        for (int v = 0; v < 256; v++) send(2'd1, W'(v), "R3 signed sweep");
        for (int v = 255; v >= 0; v -= 3) send(2'd1, W'(v), "R3 signed descend");

        send(2'd2, 8'd77, "R4 seq break");
        for (int v = 0; v < 256; v++) send(2'd2, W'(v), "R4 seq ramp");
        send(2'd2, 8'd0, "R4 seq wrap");
        for (int v = 0; v < 40; v++) send(2'd2, W'(v * 37), "R4 seq jumps");

        for (int lp = 0; lp < 3; lp++)
            for (int v = 0; v <= PAT_LAST; v++) send(2'd3, W'(v), "R5 pattern loop");
        send(2'd3, 8'd11, "R5 pattern beyond last");
        send(2'd3, 8'd12, "R5 pattern step above last");
        send(2'd3, 8'd10, "R5 pattern jump");
        send(2'd3, 8'd0, "R5 pattern wrap");
        send(2'd2, 8'd1, "R4 seq after pattern");
        send(2'd0, 8'd2, "R2 plain successor not frozen");

        // Back-to-back burst, changing mode on every transfer.
        for (int i = 0; i < 66; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk(out_valid === 1'b1 && out_data === burst_q[i-2], "R7 burst out_data",
                    int'(out_data), int'(burst_q[i-2]));
            end
            if (i < 64) begin
                burst_q[i] = W'(i * 3 + ((i % 4 == 2) ? 0 : i * 17));
                if (i % 4 >= 2 && i > 0) burst_q[i] = succ_of(burst_q[i-1], 2'(i % 4));
                model(2'(i % 4), burst_q[i]);
                in_valid = 1'b1; in_mode = 2'(i % 4); in_data = burst_q[i];
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 out_valid after burst", int'(out_valid), 0);
        chk(toggles_coded === CNT_W'(m_coded), "R9 burst toggles_coded", int'(toggles_coded), m_coded);
        chk(toggles_plain === CNT_W'(m_plain), "R9 burst toggles_plain", int'(toggles_plain), m_plain);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog expired act=%0d exp=%0d", nchk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule